// File: doc/BRIEF.md
# I/O Page Translator with Fault Capture

This block translates the virtual address of a direct memory access request from a bus device into a physical address. A request names an I/O virtual address and whether it is a write. The window mask marks the address bits that select the I/O window, and the block clears them to get a window-relative address. It then takes the page number of that address and uses it to index a table of one 32-bit entry per 4 KB page. The table starts at the base register value times sixteen. The block fetches the entry over a memory read port that has a request/ready handshake, and then decides whether the access is allowed.

An allowed access returns a physical address built from the page frame bits of the entry and the page offset of the request. A refused access returns an error. It also loads a fault status word with a fixed pattern and loads a fault address register with the page-aligned virtual address. A second fault on top of an earlier one is flagged as a multiple error. The block handles one request at a time and keeps no cache of entries, so every request costs one table read.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `pte_rd_req` is 0, and `fault_status` and `fault_addr` are 0.
- R2: The entry read address is `base_reg * 16 + 4 * ((req_vaddr & ~win_mask) >> 12)`, a 36-bit value.
- R3: When an access is allowed, `resp_fault` is 0 and `resp_paddr` is `{entry[31:8], req_vaddr[11:0]}`.
- R4: When entry bit 1 (valid) is 0, the response has `resp_fault` = 1 for both reads and writes.
- R5: A write whose entry has bit 2 (writable) clear is refused with `resp_fault` = 1. A read needs only bit 1 and is allowed whatever bit 2 holds.
- R6: On a fault, `fault_status` has bits 31, 30 and 17 set and 4'h8 in bits [23:20], with bit 18 set only for reads. A first fault writes 32'hC082_0000 for a write and 32'hC086_0000 for a read.
- R7: On a fault, `fault_addr` is loaded with the request address with bits [11:0] cleared.
- R8: A fault that arrives while `fault_status` bit 17 is already set also sets bit 19, and it overwrites `fault_addr`.
- R9: An allowed access leaves `fault_status` and `fault_addr` unchanged.
- R10: `pte_rd_req` stays high with a stable `pte_rd_addr` until the cycle in which `pte_rd_ready` is 1, and it is low in the next cycle. `resp_valid` then goes high for one cycle, two cycles after that ready cycle.
- R11: `req_ready` is 1 only while no translation is in flight. While it is 0, `req_valid` and `req_vaddr` have no effect on the entry address or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | I/O virtual address |
| req_ready | output | 1 | Block can accept a request |
| base_reg | input | 32 | Table base, in units of 16 bytes |
| win_mask | input | 32 | Window bits to strip from the address |
| pte_rd_req | output | 1 | Entry read request |
| pte_rd_addr | output | 36 | Entry byte address |
| pte_rd_ready | input | 1 | Entry read completes, data valid |
| pte_rd_data | input | 32 | Entry read data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Response is a refusal |
| resp_paddr | output | 36 | Translated physical address |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Page-aligned faulting address |

## Verification
Reads and writes run against entries that are valid and writable, valid and read-only, and invalid. This separates the valid check from the write-permission check and shows that reads ignore the write bit. Two window masks, a 16 MB window and a 1 GB window, together with different base values, show that window bits are stripped before the index is formed. Varying the number of cycles before the entry read completes, and toggling request inputs while the block is busy, exercise the handshake and show that no new request is taken mid-flight. A refused write followed by a refused read tells the first-fault status word apart from the multiple-error word, and also checks that the read flag follows the access type.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    // page geometry
    localparam int PAGE_SHIFT   = 12;
    localparam int IDX_SHIFT    = PAGE_SHIFT - 2;   // one 4-byte entry per page
    localparam int BASE_SCALE   = 4;                // base register counts 16-byte units

    // entry fields
    localparam int PTE_VALID    = 1;
    localparam int PTE_WRITE    = 2;
    localparam int PTE_PPN_LSB  = 8;

    // fault status word fields
    localparam int ST_W         = 32;
    localparam int ST_ERR       = 31;
    localparam int ST_LATE      = 30;
    localparam int ST_RSV_LSB   = 20;
    localparam logic [3:0] ST_RSV_VAL = 4'h8;
    localparam int ST_MULTI     = 19;
    localparam int ST_READ      = 18;
    localparam int ST_AVALID    = 17;

    typedef enum logic [1:0] {
        XL_IDLE,
        XL_FETCH,
        XL_CHECK,
        XL_RESP
    } xl_state_e;

    typedef struct packed {
        logic is_read;
        logic multi;
    } fault_evt_t;

    function automatic logic [ST_W-1:0] fault_word(input fault_evt_t evt);
        logic [ST_W-1:0] w;
        w = '0;
        w[ST_ERR]                   = 1'b1;
        w[ST_LATE]                  = 1'b1;
        w[ST_RSV_LSB +: 4]          = ST_RSV_VAL;
        w[ST_AVALID]                = 1'b1;
        w[ST_READ]                  = evt.is_read;
        w[ST_MULTI]                 = evt.multi;
        return w;
    endfunction

endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr
    import iopt_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int BASE_W = 32,
    localparam int EA_W  = BASE_W + BASE_SCALE
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   win_mask,
    input  logic [BASE_W-1:0] base,
    output logic [EA_W-1:0]   ent_addr
);
    logic [VA_W-1:0] rel_va;
    logic [VA_W-1:0] idx_off;

    always_comb begin
        rel_va   = vaddr & ~win_mask;
        idx_off  = (rel_va >> IDX_SHIFT) & ~(VA_W'(3));
        ent_addr = {base, {BASE_SCALE{1'b0}}} + EA_W'(idx_off);
    end
endmodule

// File: rtl/iopt_perm.sv
module iopt_perm
    import iopt_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PTE_W = 32,
    localparam int PA_W = PTE_W - PTE_PPN_LSB + PAGE_SHIFT
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic [VA_W-1:0]  vaddr,
    output logic             allow,
    output logic [PA_W-1:0]  paddr
);
    logic unused_bits;

    always_comb begin
        allow       = pte[PTE_VALID] && (!is_write || pte[PTE_WRITE]);
        paddr       = {pte[PTE_W-1:PTE_PPN_LSB], vaddr[PAGE_SHIFT-1:0]};
        unused_bits = ^{pte[PTE_PPN_LSB-1:PTE_WRITE+1], pte[0], vaddr[VA_W-1:PAGE_SHIFT]};
    end
endmodule

// File: rtl/iopt_fault_log.sv
module iopt_fault_log
    import iopt_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            log_en,
    input  logic            is_read,
    input  logic [VA_W-1:0] vaddr,
    output logic [ST_W-1:0] status,
    output logic [VA_W-1:0] addr
);
    fault_evt_t evt;

    always_comb begin
        evt.is_read = is_read;
        evt.multi   = status[ST_AVALID];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            addr   <= '0;
        end else if (log_en) begin
            status <= fault_word(evt);
            addr   <= {vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int BASE_W = 32,
    parameter int PTE_W  = 32,
    localparam int EA_W  = BASE_W + BASE_SCALE,
    localparam int PA_W  = PTE_W - PTE_PPN_LSB + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    input  logic [BASE_W-1:0] base_reg,
    input  logic [VA_W-1:0]   win_mask,
    output logic              pte_rd_req,
    output logic [EA_W-1:0]   pte_rd_addr,
    input  logic              pte_rd_ready,
    input  logic [PTE_W-1:0]  pte_rd_data,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [ST_W-1:0]   fault_status,
    output logic [VA_W-1:0]   fault_addr
);
    xl_state_e         state_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [PTE_W-1:0]  pte_q;
    logic              fault_q;
    logic [PA_W-1:0]   pa_q;

    logic              allow;
    logic [PA_W-1:0]   pa_calc;
    logic              log_en;

    iopt_entry_addr #(.VA_W(VA_W), .BASE_W(BASE_W)) u_eaddr (
        .vaddr    (va_q),
        .win_mask (win_mask),
        .base     (base_reg),
        .ent_addr (pte_rd_addr)
    );

    iopt_perm #(.VA_W(VA_W), .PTE_W(PTE_W)) u_perm (
        .pte      (pte_q),
        .is_write (wr_q),
        .vaddr    (va_q),
        .allow    (allow),
        .paddr    (pa_calc)
    );

    assign log_en = (state_q == XL_CHECK) && !allow;

    iopt_fault_log #(.VA_W(VA_W)) u_flog (
        .clk     (clk),
        .rst     (rst),
        .log_en  (log_en),
        .is_read (!wr_q),
        .vaddr   (va_q),
        .status  (fault_status),
        .addr    (fault_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XL_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            unique case (state_q)
                XL_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        state_q <= XL_FETCH;
                    end
                end
                XL_FETCH: begin
                    if (pte_rd_ready) begin
                        pte_q   <= pte_rd_data;
                        state_q <= XL_CHECK;
                    end
                end
                XL_CHECK: begin
                    fault_q <= !allow;
                    pa_q    <= allow ? pa_calc : '0;
                    state_q <= XL_RESP;
                end
                XL_RESP: begin
                    state_q <= XL_IDLE;
                end
                default: state_q <= XL_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == XL_IDLE);
    assign pte_rd_req = (state_q == XL_FETCH);
    assign resp_valid = (state_q == XL_RESP);
    assign resp_fault = fault_q;
    assign resp_paddr = pa_q;
endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk #(
    parameter int EA_W = 36
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            pte_rd_req,
    input logic            pte_rd_ready,
    input logic [EA_W-1:0] pte_rd_addr,
    input logic            resp_valid,
    input logic            resp_fault,
    input logic [31:0]     fault_status,
    input logic [11:0]     fault_off
);
    // R10: held request with stable address until ready
    a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (pte_rd_req && !pte_rd_ready) |=> (pte_rd_req && $stable(pte_rd_addr)));

    // R10: one fetch per translation
    a_r10_drop_after_ready: assert property (@(posedge clk) disable iff (rst)
        (pte_rd_req && pte_rd_ready) |=> !pte_rd_req);

    // R10: response strobe lasts one cycle
    a_r10_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R11: no acceptance while a fetch or response is in flight
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (pte_rd_req || resp_valid) |-> !req_ready);

    // R6: fixed pattern present after a fault
    a_r6_status_pattern: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (fault_status[31:30] == 2'b11 &&
            fault_status[23:20] == 4'h8 && fault_status[17]));

    // R7: logged address is page aligned
    a_r7_page_aligned: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (fault_off == 12'h000));

    // R9: success leaves the status word alone
    a_r9_status_quiet: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> $stable(fault_status));
endmodule

bind iopt_xlate iopt_xlate_chk #(.EA_W(EA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .pte_rd_req   (pte_rd_req),
    .pte_rd_ready (pte_rd_ready),
    .pte_rd_addr  (pte_rd_addr),
    .resp_valid   (resp_valid),
    .resp_fault   (resp_fault),
    .fault_status (fault_status),
    .fault_off    (fault_addr[11:0])
);

// File: tb/tb_iopt_xlate.sv
module tb_iopt_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic [31:0] base_reg = '0;
    logic [31:0] win_mask = '0;
    logic        pte_rd_req;
    logic [35:0] pte_rd_addr;
    logic        pte_rd_ready = 1'b0;
    logic [31:0] pte_rd_data = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [35:0] resp_paddr;
    logic [31:0] fault_status;
    logic [31:0] fault_addr;

    int n_checks = 0;
    int n_err    = 0;
    logic had_fault = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iopt_xlate dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .base_reg(base_reg), .win_mask(win_mask),
        .pte_rd_req(pte_rd_req), .pte_rd_addr(pte_rd_addr),
        .pte_rd_ready(pte_rd_ready), .pte_rd_data(pte_rd_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [35:0] exp_entry(input logic [31:0] b, input logic [31:0] m,
                                              input logic [31:0] va);
        logic [63:0] t;
        t = 64'(b) * 16 + 64'((va & ~m) >> 12) * 4;
        return t[35:0];
    endfunction

    function automatic logic [31:0] exp_status(input logic rd, input logic prior);
        return 32'hC082_0000 | (rd ? 32'h0004_0000 : 32'h0) | (prior ? 32'h0008_0000 : 32'h0);
    endfunction

    // drives one translation; reports fault, paddr, entry address, latency, handshake errors
    task automatic run_xlate(input logic [31:0] va, input logic wr, input logic [31:0] pte,
                             input int dly, input logic hold_busy,
                             output logic flt, output logic [35:0] pa,
                             output logic [35:0] ea, output int lat, output int hs_bad);
        int waited;
        hs_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va;
        @(negedge clk);
        if (hold_busy) begin req_vaddr = ~va; req_write = ~wr; end
        else req_valid = 1'b0;
        waited = 0;
        while (!pte_rd_req && waited < 50) begin @(negedge clk); waited++; end
        ea = pte_rd_addr;
        for (int k = 0; k < dly; k++) begin
            if (!pte_rd_req || pte_rd_addr !== ea || req_ready) hs_bad++;
            @(negedge clk);
        end
        if (!pte_rd_req || pte_rd_addr !== ea) hs_bad++;
        pte_rd_ready = 1'b1; pte_rd_data = pte;
        @(negedge clk);
        pte_rd_ready = 1'b0; pte_rd_data = '0;
        if (pte_rd_req) hs_bad++;
        lat = 1;
        while (!resp_valid && lat < 50) begin @(negedge clk); lat++; end
        flt = resp_fault; pa = resp_paddr;
        req_valid = 1'b0;
        @(negedge clk);
        if (resp_valid) hs_bad++;
    endtask

    task automatic t_reset();
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 resp_valid", 64'(resp_valid), 64'd0);
        check("R1 pte_rd_req", 64'(pte_rd_req), 64'd0);
        check("R1 fault_status", 64'(fault_status), 64'd0);
        check("R1 fault_addr", 64'(fault_addr), 64'd0);
    endtask

    task automatic t_ok(input string tag, input logic [31:0] b, input logic [31:0] m,
                        input logic [31:0] va, input logic wr, input logic [31:0] pte, input int dly);
        logic f; logic [35:0] pa, ea; int lat, hb;
        logic [31:0] st0, fa0;
        base_reg = b; win_mask = m;
        st0 = fault_status; fa0 = fault_addr;
        run_xlate(va, wr, pte, dly, 1'b0, f, pa, ea, lat, hb);
        check({tag, " R2 entry address"}, 64'(ea), 64'(exp_entry(b, m, va)));
        check({tag, " R3 no fault"}, 64'(f), 64'd0);
        check({tag, " R3 paddr"}, 64'(pa), 64'({pte[31:8], va[11:0]}));
        check({tag, " R10 latency"}, 64'(lat), 64'd2);
        check({tag, " R10 handshake"}, 64'(hb), 64'd0);
        check({tag, " R9 status kept"}, 64'(fault_status), 64'(st0));
        check({tag, " R9 addr kept"}, 64'(fault_addr), 64'(fa0));
    endtask

    task automatic t_fault(input string tag, input logic [31:0] va, input logic wr,
                           input logic [31:0] pte, input int dly);
        logic f; logic [35:0] pa, ea; int lat, hb;
        run_xlate(va, wr, pte, dly, 1'b0, f, pa, ea, lat, hb);
        check({tag, " R4/R5 fault flag"}, 64'(f), 64'd1);
        check({tag, " R6/R8 status"}, 64'(fault_status), 64'(exp_status(!wr, had_fault)));
        check({tag, " R7 fault addr"}, 64'(fault_addr), 64'({va[31:12], 12'h000}));
        check({tag, " R10 handshake"}, 64'(hb), 64'd0);
        had_fault = 1'b1;
    endtask

    task automatic t_busy_ignore();
        logic f; logic [35:0] pa, ea; int lat, hb;
        logic [31:0] va;
        va = 32'hFF45_6123;
        base_reg = 32'h0000_8000; win_mask = 32'hFF00_0000;
        run_xlate(va, 1'b0, 32'h1234_5602, 3, 1'b1, f, pa, ea, lat, hb);
        check("R11 entry address ignores busy inputs", 64'(ea), 64'(exp_entry(base_reg, win_mask, va)));
        check("R11 busy not ready", 64'(hb), 64'd0);
        check("R11 result from first request", 64'(pa), 64'({24'h123456, va[11:0]}));
        check("R11 no fault", 64'(f), 64'd0);
        check("R11 ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R3 R5: read, valid+writable, 16 MB window, immediate ready
        t_ok("rd16", 32'h0001_2340, 32'hFF00_0000, 32'hFF12_3ABC, 1'b0, 32'h0ABC_DE06, 0);
        // R5: read of read-only entry is allowed, 1 GB window, slow ready
        t_ok("rdro", 32'h0200_0000, 32'hC000_0000, 32'hC7FF_F004, 1'b0, 32'hFEDC_BA02, 3);
        // R3: write to writable entry
        t_ok("wr", 32'h0000_0010, 32'hFF00_0000, 32'hFF00_5FFF, 1'b1, 32'h0000_0106, 1);
        // R5 R6 R7: first fault, write to read-only entry
        t_fault("wrro", 32'hFF33_4567, 1'b1, 32'hFFFF_FF02, 2);
        // R4 R6 R8: read of invalid entry on top of the earlier fault
        t_fault("inv", 32'hFF0A_BFFF, 1'b0, 32'hFFFF_FF04, 0);
        // R9: success after faults keeps the log
        t_ok("after", 32'h0001_0000, 32'hFF00_0000, 32'hFF00_1001, 1'b1, 32'h00AA_0006, 2);
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule